// File: doc/BRIEF.md
# Configurable Interrupt Pin Generator

This block drives one interrupt line towards a host processor. Internal events land in a vector of pending bits. Handshake reports from a USB endpoint engine also land there, but only when a per-class filter lets them through. Software chooses which pending bits may interrupt through a mask, and a global enable bit gates the whole line. Pending bits are cleared by writing ones to them.

The line has two modes. In level mode it stays asserted for as long as an unmasked pending bit exists. In pulse mode it emits one pulse of fixed length for each qualifying event. Events that arrive while a pulse is running are merged into that pulse. A polarity bit chooses whether the asserted state is high or low. If the global enable is turned on while unmasked bits are already pending, the line reacts at once: in level mode it asserts, and in pulse mode it emits a single pulse.

Handshake filters exist for three endpoint classes: the control endpoint, the data-IN endpoints and the data-OUT endpoints. Each filter decides whether a NAK or a NYET counts in addition to an ACK.

Top module: `irqgen_top`

## Requirements
- R1: After reset, address 0 reads 0xFC, addresses 1, 2 and 3 read 0, and irq_pin is 1 (inactive for the reset polarity).
- R2: Register map: address 0 is the configuration byte, address 1 bit 0 is the global enable, address 2 is the source mask and address 3 is the pending vector. In the configuration byte, bits 7:6 hold the control-class filter, bits 5:4 the IN-class filter, bits 3:2 the OUT-class filter, bit 1 the pulse select and bit 0 the polarity. rd_data shows the register addressed by rd_addr, as it was before the clock edge, one cycle after rd_addr is presented.
- R3: A 1 on src_evt, or a qualified handshake, sets the matching pending bit at the next edge. A write to address 3 clears every bit where wr_data is 1. If a bit is set and cleared in the same cycle, the set wins.
- R4: hs_kind encodes 0 = ACK, 1 = NAK, 2 = NYET and 3 = no event. Endpoint 0 uses the control filter and sets pending bit 0. A nonzero endpoint with hs_in=1 uses the IN filter and sets bit 1. A nonzero endpoint with hs_in=0 uses the OUT filter and sets bit 2. Filter code 00 passes ACK only, 01 passes ACK and NYET, 10 passes ACK and NAK, and 11 passes ACK only.
- R5: With pulse select 0, irq_pin is asserted in the cycle after any cycle in which the enable is 1 and the pending and mask vectors share a 1 bit. It is inactive in the cycle after any cycle in which they do not.
- R6: Polarity 1 makes the asserted level high; polarity 0 makes it low. The inactive level is always the opposite.
- R7: In the cycle after any cycle in which the global enable is 0, irq_pin is inactive in either mode, and a running pulse is cut short.
- R8: With pulse select 1 and the enable set, an unmasked event presented before edge e asserts irq_pin from edge e+1 for exactly PULSE_CYC cycles.
- R9: Setting the enable while unmasked bits are pending asserts the pin at once: as a level in level mode, or as exactly one pulse in pulse mode.
- R10: In pulse mode, qualifying events that arrive up to and including the last cycle of a pulse start no new pulse. A later event starts a new pulse after at least one inactive cycle.
- R11: In pulse mode, events that arrive while the enable is 0 make no pulses of their own. Enabling afterwards gives one pulse in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW | Registered read data |
| src_evt | input | NSRC | Raw event pulses, one per pending bit |
| hs_valid | input | 1 | Handshake report valid |
| hs_kind | input | 2 | Handshake type (ACK, NAK, NYET, none) |
| hs_ep | input | EPW | Endpoint number of the handshake |
| hs_in | input | 1 | Direction of the handshake endpoint (1 = IN) |
| irq_pin | output | 1 | Interrupt line to the host |

## Verification
Some properties are checked on every cycle. The line must stay inactive while disabled. In level mode it must follow the masked pending state, and a pulse may never run longer than PULSE_CYC cycles under a steady configuration. A pending bit must be set after its event, and the write-one-to-clear path must take effect when no set competes with it. Other behaviour only shows in the bench's directed scenarios, where a cycle-accurate reference model is compared against the pin and the read port: the filter code against each handshake type and endpoint class, the exact pulse count when events are merged or spaced, the single pulse when enabling after disabled events, and the behaviour of both polarities.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;
  typedef enum logic [1:0] {
    HS_ACK  = 2'd0,
    HS_NAK  = 2'd1,
    HS_NYET = 2'd2,
    HS_NONE = 2'd3
  } hs_kind_e;

  typedef enum logic [1:0] {
    FLT_ACK      = 2'b00,
    FLT_ACK_NYET = 2'b01,
    FLT_ACK_NAK  = 2'b10,
    FLT_RSVD     = 2'b11
  } flt_e;

  // Packed from the top bit down: the field positions are decoded by software.
  typedef struct packed {
    logic [1:0] ctl_flt;
    logic [1:0] in_flt;
    logic [1:0] out_flt;
    logic       pulse_sel;
    logic       pol_hi;
  } cfg_t;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;

  localparam cfg_t CFG_RESET = '{ctl_flt: 2'b11, in_flt: 2'b11, out_flt: 2'b11,
                                 pulse_sel: 1'b0, pol_hi: 1'b0};
endpackage

// File: rtl/irqgen_hsfilt.sv
module irqgen_hsfilt
  import irqgen_pkg::*;
#(
  parameter int EPW = 3
) (
  input  logic           hs_valid,
  input  logic [1:0]     hs_kind,
  input  logic [EPW-1:0] hs_ep,
  input  logic           hs_in,
  input  cfg_t           cfg,
  output logic [2:0]     raise
);
  localparam int NCLS = 3;

  logic [1:0]      flt [NCLS];
  logic [NCLS-1:0] cls_hit;

  assign flt[0] = cfg.ctl_flt;
  assign flt[1] = cfg.in_flt;
  assign flt[2] = cfg.out_flt;

  // Endpoint zero is always the control class, whatever the direction.
  assign cls_hit[0] = (hs_ep == '0);
  assign cls_hit[1] = (hs_ep != '0) &&  hs_in;
  assign cls_hit[2] = (hs_ep != '0) && !hs_in;

  genvar g;
  generate
    for (g = 0; g < NCLS; g++) begin : g_cls
      logic pass;
      always_comb begin
        pass = 1'b0;
        case (hs_kind)
          HS_ACK:  pass = 1'b1;
          HS_NAK:  pass = (flt[g] == FLT_ACK_NAK);
          HS_NYET: pass = (flt[g] == FLT_ACK_NYET);
          default: pass = 1'b0;
        endcase
      end
      assign raise[g] = hs_valid & cls_hit[g] & pass;
    end
  endgenerate
endmodule

// File: rtl/irqgen_regs.sv
module irqgen_regs
  import irqgen_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  input  logic [NSRC-1:0] set_vec,
  output cfg_t            cfg_q,
  output logic            glb_en,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] pend_q,
  output logic [DW-1:0]   rd_data
);
  localparam int CFGW = $bits(cfg_t);

  logic            wr_cfg, wr_ctrl, wr_mask, wr_pend;
  logic [NSRC-1:0] clr_vec;

  assign wr_cfg  = wr_en && (wr_addr == A_CFG);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_mask = wr_en && (wr_addr == A_MASK);
  assign wr_pend = wr_en && (wr_addr == A_PEND);
  assign clr_vec = wr_pend ? wr_data[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RESET;
      glb_en <= 1'b0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= cfg_t'(wr_data[CFGW-1:0]);
      if (wr_ctrl) glb_en <= wr_data[0];
      if (wr_mask) mask_q <= wr_data[NSRC-1:0];
      // A new event outranks a clear aimed at the same bit.
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CFG:   rd_data <= DW'(cfg_q);
        A_CTRL:  rd_data <= DW'(glb_en);
        A_MASK:  rd_data <= DW'(mask_q);
        default: rd_data <= DW'(pend_q);
      endcase
    end
  end
endmodule

// File: rtl/irqgen_pulse.sv
module irqgen_pulse #(
  parameter int PULSE_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] left_q;

  // A trigger is taken only once the count has reached zero. The final pin
  // register therefore always shows one inactive cycle between two pulses.
  always_ff @(posedge clk) begin
    if (rst || clr)       left_q <= '0;
    else if (left_q != 0) left_q <= left_q - 1'b1;
    else if (trig)        left_q <= CW'(PULSE_CYC);
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/irqgen_top.sv
module irqgen_top
  import irqgen_pkg::*;
#(
  parameter int NSRC       = 8,
  parameter int DW         = 8,
  parameter int EPW        = 3,
  parameter int PULSE_CYC  = 15,
  parameter int HS_CTL_BIT = 0,
  parameter int HS_IN_BIT  = 1,
  parameter int HS_OUT_BIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NSRC-1:0] src_evt,
  input  logic            hs_valid,
  input  logic [1:0]      hs_kind,
  input  logic [EPW-1:0]  hs_ep,
  input  logic            hs_in,
  output logic            irq_pin
);
  cfg_t            cfg_q;
  logic            glb_en, en_prev;
  logic [NSRC-1:0] mask_q, pend_q, hs_vec, set_vec;
  logic [2:0]      hs_raise;
  logic            pend_hit, new_hit, en_rise, trig, pulse_clr, pulse_on, asserted;

  irqgen_hsfilt #(.EPW(EPW)) u_filt (
    .hs_valid (hs_valid),
    .hs_kind  (hs_kind),
    .hs_ep    (hs_ep),
    .hs_in    (hs_in),
    .cfg      (cfg_q),
    .raise    (hs_raise)
  );

  always_comb begin
    hs_vec             = '0;
    hs_vec[HS_CTL_BIT] = hs_raise[0];
    hs_vec[HS_IN_BIT]  = hs_raise[1];
    hs_vec[HS_OUT_BIT] = hs_raise[2];
  end

  assign set_vec = src_evt | hs_vec;

  irqgen_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .set_vec (set_vec),
    .cfg_q   (cfg_q),
    .glb_en  (glb_en),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b0;
    else     en_prev <= glb_en;
  end

  assign pend_hit  = |(pend_q & mask_q);
  assign new_hit   = |(set_vec & mask_q);
  assign en_rise   = glb_en & ~en_prev;
  // An enable that rises while bits are pending counts as one trigger. Events
  // seen while disabled are not queued for replay.
  assign trig      = cfg_q.pulse_sel & glb_en & (new_hit | (en_rise & pend_hit));
  assign pulse_clr = ~cfg_q.pulse_sel | ~glb_en;

  irqgen_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .clr    (pulse_clr),
    .trig   (trig),
    .active (pulse_on)
  );

  assign asserted = glb_en & (cfg_q.pulse_sel ? pulse_on : pend_hit);

  always_ff @(posedge clk) begin
    if (rst) irq_pin <= 1'b1;
    else     irq_pin <= asserted ~^ cfg_q.pol_hi;
  end
endmodule

// File: rtl/irqgen_chk.sv
module irqgen_chk
  import irqgen_pkg::*;
#(
  parameter int NSRC      = 8,
  parameter int DW        = 8,
  parameter int PULSE_CYC = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            irq_pin,
  input cfg_t            cfg,
  input logic            glb_en,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] set_vec
);
  localparam int RW = $clog2(PULSE_CYC + 2) + 1;

  cfg_t          cfg_d;
  logic [RW-1:0] run;

  // Counts how long the pin has stayed active under an unchanged pulse configuration.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_d <= CFG_RESET;
      run   <= '0;
    end else begin
      cfg_d <= cfg;
      if ((irq_pin == cfg.pol_hi) && cfg.pulse_sel && (cfg_d == cfg)) begin
        if (run != '1) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (irq_pin && (pend == '0) && !glb_en && (cfg == CFG_RESET)));

  a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == A_PEND) && (set_vec == '0))
      |=> ((pend & $past(wr_data[NSRC-1:0])) == '0));

  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> (irq_pin == !$past(cfg.pol_hi)));

  a_r5_level_on: assert property (@(posedge clk) disable iff (rst)
    (glb_en && !cfg.pulse_sel && ((pend & mask) != '0)) |=> (irq_pin == $past(cfg.pol_hi)));

  a_r5_level_off: assert property (@(posedge clk) disable iff (rst)
    (!cfg.pulse_sel && ((pend & mask) == '0)) |=> (irq_pin == !$past(cfg.pol_hi)));

  a_r8_max_width: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(PULSE_CYC));
endmodule

bind irqgen_top irqgen_chk #(.NSRC(NSRC), .DW(DW), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .irq_pin (irq_pin),
  .cfg     (cfg_q),
  .glb_en  (glb_en),
  .mask    (mask_q),
  .pend    (pend_q),
  .set_vec (set_vec)
);

// File: tb/sim_irqgen_top.sv
module sim_irqgen_top;
  localparam int NSRC = 8;
  localparam int DW   = 8;
  localparam int EPW  = 3;
  localparam int P    = 15;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [1:0]      rd_addr = '0;
  logic [DW-1:0]   rd_data;
  logic [NSRC-1:0] src_evt = '0;
  logic            hs_valid = 1'b0;
  logic [1:0]      hs_kind = 2'd3;
  logic [EPW-1:0]  hs_ep = '0;
  logic            hs_in = 1'b0;
  logic            irq_pin;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqgen_top #(.NSRC(NSRC), .DW(DW), .EPW(EPW), .PULSE_CYC(P)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_evt(src_evt), .hs_valid(hs_valid),
    .hs_kind(hs_kind), .hs_ep(hs_ep), .hs_in(hs_in), .irq_pin(irq_pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_cfg, m_mask, m_pend, m_rd;
  logic       m_en, m_en_prev, m_pin;
  int         m_left;

  function automatic logic [7:0] m_hs(input logic v, input logic [1:0] k,
                                      input int ep, input logic din, input logic [7:0] c);
    logic [1:0] f;
    int b;
    logic ok;
    if (ep == 0) begin f = c[7:6]; b = 0; end
    else if (din) begin f = c[5:4]; b = 1; end
    else begin f = c[3:2]; b = 2; end
    ok = (k == 2'd0) || (k == 2'd1 && f == 2'b10) || (k == 2'd2 && f == 2'b01);
    m_hs = (v && ok) ? (8'h01 << b) : 8'h00;
  endfunction

  always @(posedge clk) begin
    logic [7:0] setv, clr;
    logic trig, act;
    if (rst) begin
      m_cfg = 8'hFC; m_mask = 0; m_pend = 0; m_rd = 0;
      m_en = 0; m_en_prev = 0; m_pin = 1; m_left = 0;
    end else begin
      setv = src_evt | m_hs(hs_valid, hs_kind, int'(hs_ep), hs_in, m_cfg);
      act  = m_en && (m_cfg[1] ? (m_left > 0) : ((m_pend & m_mask) != 0));
      trig = m_cfg[1] && m_en && (((setv & m_mask) != 0) ||
             (!m_en_prev && ((m_pend & m_mask) != 0)));
      m_pin = act ? m_cfg[0] : !m_cfg[0];
      case (rd_addr)
        2'd0: m_rd = m_cfg;
        2'd1: m_rd = {7'd0, m_en};
        2'd2: m_rd = m_mask;
        default: m_rd = m_pend;
      endcase
      if (!m_cfg[1] || !m_en) m_left = 0;
      else if (m_left > 0)    m_left = m_left - 1;
      else if (trig)          m_left = P;
      m_en_prev = m_en;
      clr = (wr_en && wr_addr == 2'd3) ? wr_data : 8'h00;
      m_pend = (m_pend & ~clr) | setv;
      if (wr_en && wr_addr == 2'd0) m_cfg  = wr_data;
      if (wr_en && wr_addr == 2'd1) m_en   = wr_data[0];
      if (wr_en && wr_addr == 2'd2) m_mask = wr_data;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R5 R6 R7 R8 pin vs model", {31'd0, irq_pin}, {31'd0, m_pin});
      chk("R2 read port vs model", {24'd0, rd_data}, {24'd0, m_rd});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    step();
    v = rd_data;
  endtask

  task automatic hs(input logic [1:0] k, input int ep, input logic din);
    hs_valid = 1'b1; hs_kind = k; hs_ep = EPW'(ep); hs_in = din;
    step();
    hs_valid = 1'b0; hs_kind = 2'd3;
  endtask

  task automatic measure(input int n, input int a1, input int a2, input logic [7:0] v,
                         input logic pol, output int act, output int rises);
    logic prev;
    act = 0; rises = 0; prev = (irq_pin == pol);
    for (int i = 0; i < n; i++) begin
      src_evt = (i == a1 || i == a2) ? v : 8'h00;
      step();
      if (irq_pin == pol) act++;
      if ((irq_pin == pol) && !prev) rises++;
      prev = (irq_pin == pol);
    end
    src_evt = 8'h00;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [7:0] v;
    int a, r;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1 pin idle after reset", {31'd0, irq_pin}, 32'd1);
    rd(2'd0, v); chk("R1 cfg reset value", {24'd0, v}, 32'hFC);
    rd(2'd2, v); chk("R1 mask reset value", {24'd0, v}, 32'h00);
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R2 mask readback", {24'd0, v}, 32'hFF);

    // R4: filter code 11 passes only ACK
    hs(2'd1, 0, 1'b0);
    rd(2'd3, v); chk("R4 NAK blocked by code 11", {24'd0, v}, 32'h00);
    hs(2'd0, 5, 1'b1);
    rd(2'd3, v); chk("R4 ACK on IN ep sets bit1", {24'd0, v}, 32'h02);
    wr(2'd0, 8'h9C);
    hs(2'd1, 0, 1'b1);
    rd(2'd3, v); chk("R4 NAK on ep0 with code 10", {24'd0, v}, 32'h03);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R3 write one clears", {24'd0, v}, 32'h00);
    hs(2'd2, 3, 1'b1);
    rd(2'd3, v); chk("R4 NYET on IN with code 01", {24'd0, v}, 32'h02);
    hs(2'd2, 3, 1'b0);
    rd(2'd3, v); chk("R4 NYET on OUT with code 11 ignored", {24'd0, v}, 32'h02);
    hs(2'd0, 7, 1'b0);
    rd(2'd3, v); chk("R4 ACK on OUT sets bit2", {24'd0, v}, 32'h06);

    // level mode
    step();
    chk("R7 disabled pin idle", {31'd0, irq_pin}, 32'd1);
    wr(2'd1, 8'h01); step();
    chk("R9 enable with pending asserts low", {31'd0, irq_pin}, 32'd0);
    wr(2'd0, 8'h9D); step();
    chk("R6 polarity high asserted", {31'd0, irq_pin}, 32'd1);
    wr(2'd2, 8'h01); step();
    chk("R5 masked sources inactive", {31'd0, irq_pin}, 32'd0);
    wr(2'd2, 8'hFF); step();
    chk("R5 unmasked asserts", {31'd0, irq_pin}, 32'd1);
    wr(2'd3, 8'h06); step();
    chk("R5 cleared pending releases", {31'd0, irq_pin}, 32'd0);
    // R3 set and clear in the same cycle
    src_evt = 8'h01;
    wr(2'd3, 8'h01);
    src_evt = 8'h00;
    rd(2'd3, v); chk("R3 set wins over clear", {24'd0, v}, 32'h01);
    wr(2'd3, 8'hFF);

    // pulse mode, active high
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h9F);
    wr(2'd1, 8'h01);
    step();
    measure(40, 0, -1, 8'h10, 1'b1, a, r);
    chk("R8 single pulse width", a, P);
    chk("R8 single pulse count", r, 1);
    measure(50, 0, 3, 8'h20, 1'b1, a, r);
    chk("R10 merged event count", r, 1);
    measure(60, 0, P, 8'h20, 1'b1, a, r);
    chk("R10 event in last cycle merged", r, 1);
    measure(60, 0, P + 1, 8'h20, 1'b1, a, r);
    chk("R10 later event gives second pulse", r, 2);
    chk("R10 two pulse widths", a, 2 * P);
    wr(2'd3, 8'hFF);

    // R11: events while disabled, then enable
    wr(2'd1, 8'h00);
    src_evt = 8'h01; step(); src_evt = 8'h02; step(); src_evt = 8'h04; step();
    src_evt = 8'h00; step();
    chk("R11 no pulse while disabled", {31'd0, irq_pin}, 32'd0);
    wr(2'd1, 8'h01);
    measure(40, -1, -1, 8'h00, 1'b1, a, r);
    chk("R9 R11 one pulse on enable", r, 1);
    chk("R9 R11 pulse width on enable", a, P);

    // pulse mode, active low, then disable mid-pulse
    wr(2'd0, 8'h9E); step();
    measure(40, 0, -1, 8'h08, 1'b0, a, r);
    chk("R6 low pulse count", r, 1);
    chk("R6 low pulse width", a, P);
    measure(4, 0, -1, 8'h08, 1'b0, a, r);
    wr(2'd1, 8'h00); step();
    chk("R7 disable cuts pulse", {31'd0, irq_pin}, 32'd1);
    repeat (5) step();
    finish_up();
  end
endmodule